// File: doc/BRIEF.md
# GPIO Line Interrupt Front End

This block turns sixteen general-purpose input pins, arranged as two ports of eight, into interrupt sources. Each pin passes through a two-stage synchronizer. Each line can then be enabled or not. It can trigger on a level or on an edge, and on low/falling or high/rising polarity. A per-port status byte shows which enabled lines currently request service. Edge events are held in a pending latch until software clears them by writing ones to the acknowledge location. Level conditions follow the pin and need no acknowledge.

All sixteen lines feed one shared interrupt output. Software reads the status bytes to find the source. A register bus with a single-cycle write strobe and a combinational read port gives access to four locations per port. The address is `{port, sel}`. Sel 0 is enable. Sel 1 is the trigger kind (0 level, 1 edge). Sel 2 is the polarity (0 low/falling, 1 high/rising). Sel 3 reads the status and takes the acknowledge on a write. Line n sits in port n/8 at bit n mod 8.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, enable, kind, polarity and pending state are zero. Every one of the eight locations reads 0x00 and `irq_o` is low.
- R2: Writes to sel 0, 1 and 2 of a port store the written byte, and that byte reads back from the same address. Writes to one port leave the other port's registers unchanged.
- R3: An enabled level-high line (kind 0, polarity 1) shows status 1 while its synchronized pin is 1, and 0 once the pin returns to 0.
- R4: An enabled level-low line (kind 0, polarity 0) shows status 1 while its synchronized pin is 0.
- R5: An enabled rising-edge line (kind 1, polarity 1) latches a pin transition from 0 to 1. Its status stays 1 after the pin falls again, until it is acknowledged.
- R6: An enabled falling-edge line (kind 1, polarity 0) latches a transition from 1 to 0 and ignores a rising transition.
- R7: Writing to sel 3 clears the pending latch of each line written as 1. Bits written as 0 have no effect. The write does not affect a level-mode line's status.
- R8: Clearing a line's enable bit clears its pending latch. Edges that arrive while the line is disabled are not recorded, so re-enabling it gives status 0.
- R9: `irq_o` is high exactly when any status bit of either port is 1.
- R10: A reconfiguration done in the order enable=0, polarity, kind, enable produces no status bit for an edge line whose pin did not move.
- R11: A pin change reaches the status two clock edges after it is applied. After one edge the status still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 16 | Raw pin levels; bit n is line n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | `{port, sel}` register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Port A's four low lines are set to one trigger mode each: level-high, level-low, rising and falling. Each pin is then driven in turn. This shows whether the kind and polarity decode reaches the right line, and that an edge line ignores the opposite transition. Single-cycle pulses separate latched edge events from level tracking. One-cycle and two-cycle samples after a pin change pin down the synchronizer depth. A port-B line and per-bit acknowledge masks, including masks that miss the pending bit, test the port selection, write-one-clear and the shared request.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_KIND = 2'd1,
    SEL_POL  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic         wr_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] kind_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] en_q, kind_q, pol_q, pend_q, prev_q;
  logic [W-1:0] en_d, ack, rise, fall, hit, pend_d;

  always_comb begin
    en_d   = (wr_i && sel_i == SEL_EN) ? wdata_i : en_q;
    ack    = (wr_i && sel_i == SEL_STAT) ? wdata_i : '0;
    rise   = sync_i & ~prev_q;
    fall   = ~sync_i & prev_q;
    hit    = kind_q & ((pol_q & rise) | (~pol_q & fall));
    // disabling drops pending; a new edge wins over a same-cycle ack
    pend_d = en_d & ((pend_q & ~ack) | hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      prev_q <= sync_i;
      if (wr_i && sel_i == SEL_KIND) kind_q <= wdata_i;
      if (wr_i && sel_i == SEL_POL)  pol_q  <= wdata_i;
    end
  end

  assign en_o     = en_q;
  assign kind_o   = kind_q;
  assign pol_o    = pol_q;
  assign status_o = en_q & ((kind_q & pend_q) | (~kind_q & ~(sync_i ^ pol_q)));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack & ~hit)) |=> ((pend_q & $past(ack & ~hit)) == '0));

  a_r5_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_q & en_d & ~ack)) |=>
      ((pend_q & $past(pend_q & en_d & ~ack)) == $past(pend_q & en_d & ~ack)));

  a_r8_no_pend_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~en_q) == '0);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PORTS*PORT_W-1:0]      pin_i,
  input  logic                             wr_en_i,
  input  logic [$clog2(NUM_PORTS)+1:0]     addr_i,
  input  logic [PORT_W-1:0]                wdata_i,
  output logic [PORT_W-1:0]                rdata_o,
  output logic                             irq_o
);
  localparam int PSEL_W = $clog2(NUM_PORTS);
  localparam int ADDR_W = PSEL_W + 2;

  logic [NUM_PORTS*PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] en_a [NUM_PORTS];
  logic [PORT_W-1:0] kind_a [NUM_PORTS];
  logic [PORT_W-1:0] pol_a [NUM_PORTS];
  logic [PORT_W-1:0] stat_a [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_req;

  reg_sel_e          sel;
  logic [PSEL_W-1:0] port_idx;

  assign sel      = reg_sel_e'(addr_i[1:0]);
  assign port_idx = addr_i[ADDR_W-1:2];

  gpio_irq_sync #(.W(NUM_PORTS*PORT_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_irq_port #(.W(PORT_W)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (pin_sync[p*PORT_W +: PORT_W]),
      .wr_i    (wr_en_i && (port_idx == PSEL_W'(p))),
      .sel_i   (sel),
      .wdata_i (wdata_i),
      .en_o    (en_a[p]),
      .kind_o  (kind_a[p]),
      .pol_o   (pol_a[p]),
      .status_o(stat_a[p])
    );
    assign port_req[p] = |stat_a[p];
  end

  assign irq_o = |port_req;

  always_comb begin
    unique case (sel)
      SEL_EN:   rdata_o = en_a[port_idx];
      SEL_KIND: rdata_o = kind_a[port_idx];
      SEL_POL:  rdata_o = pol_a[port_idx];
      default:  rdata_o = stat_a[port_idx];
    endcase
  end

  a_r9_status_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_STAT && rdata_o != '0) |-> irq_o);
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pin = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    string    req;
    string    what;
    logic [7:0] act;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .pin_i  (pin),
    .wr_en_i(wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  // monitor: pops and compares
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.act !== it.exp) begin
          fails++;
          $display("FAIL %s %s actual=%02h expected=%02h", it.req, it.what, it.act, it.exp);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [2:0] a, logic [7:0] e);
    item_t it;
    addr = a;
    #1;
    it.req = req; it.what = $sformatf("addr%0d", a); it.act = rdata; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic expect_irq(string req, logic e);
    item_t it;
    it.req = req; it.what = "irq"; it.act = {7'd0, irq}; it.exp = {7'd0, e};
    sb_q.push_back(it);
  endtask

  // R10 ordering: disable, polarity, kind, enable
  task automatic config_port(logic p, logic [7:0] en, logic [7:0] kind, logic [7:0] pol);
    wr({p, 2'd0}, 8'h00);
    wr({p, 2'd2}, pol);
    wr({p, 2'd1}, kind);
    wr({p, 2'd0}, en);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) expect_reg("R1", 3'(a), 8'h00);
    expect_irq("R1", 1'b0);
    tick(1);

    // R10 / R2: A0 level-high, A1 level-low, A2 rising, A3 falling
    wr(3'd2, 8'h05);
    wr(3'd1, 8'h0C);
    expect_reg("R10", 3'd3, 8'h00); // still disabled
    wr(3'd0, 8'h0F);
    expect_reg("R2", 3'd0, 8'h0F);
    expect_reg("R2", 3'd1, 8'h0C);
    expect_reg("R2", 3'd2, 8'h05);
    expect_reg("R2", 3'd4, 8'h00);
    expect_reg("R2", 3'd6, 8'h00);
    expect_reg("R4", 3'd3, 8'h02);  // A1 low pin active, edges idle
    expect_irq("R9", 1'b1);
    tick(1);

    // R4 / R11: A1 goes high
    pin[1] = 1'b1;
    tick(1); expect_reg("R11", 3'd3, 8'h02);
    tick(1); expect_reg("R4", 3'd3, 8'h00); expect_irq("R9", 1'b0);

    // R3 / R11: A0 level-high
    tick(1); pin[0] = 1'b1;
    tick(1); expect_reg("R11", 3'd3, 8'h00);
    tick(1); expect_reg("R3", 3'd3, 8'h01);
    tick(1); pin[0] = 1'b0;
    tick(2); expect_reg("R3", 3'd3, 8'h00);

    // R5: one-cycle pulse on A2
    tick(1); pin[2] = 1'b1;
    tick(1); pin[2] = 1'b0;
    tick(4); expect_reg("R5", 3'd3, 8'h04); expect_irq("R5", 1'b1);
    tick(3); expect_reg("R5", 3'd3, 8'h04);

    // R7: ack with bit clear does nothing, ack bit clears
    wr(3'd3, 8'hFB); expect_reg("R7", 3'd3, 8'h04);
    wr(3'd3, 8'h04); expect_reg("R7", 3'd3, 8'h00); expect_irq("R7", 1'b0);
    pin[0] = 1'b1;
    tick(3);
    wr(3'd3, 8'h01); expect_reg("R7", 3'd3, 8'h01);
    pin[0] = 1'b0;
    tick(3); expect_reg("R7", 3'd3, 8'h00);

    // R6: A3 rising ignored, falling latched
    pin[3] = 1'b1;
    tick(4); expect_reg("R6", 3'd3, 8'h00);
    pin[3] = 1'b0;
    tick(4); expect_reg("R6", 3'd3, 8'h08);
    wr(3'd3, 8'h08); expect_reg("R6", 3'd3, 8'h00);

    // R8: pending cleared by disable
    pin[2] = 1'b1;
    tick(1); pin[2] = 1'b0;
    tick(4); expect_reg("R8", 3'd3, 8'h04);
    wr(3'd0, 8'h0B); expect_reg("R8", 3'd3, 8'h00);
    // R8: edge while disabled not recorded
    pin[2] = 1'b1;
    tick(1); pin[2] = 1'b0;
    tick(4);
    wr(3'd0, 8'h0F);
    tick(2); expect_reg("R8", 3'd3, 8'h00); expect_irq("R8", 1'b0);

    // R9 / R2: port B line 7 rising
    config_port(1'b1, 8'h80, 8'h80, 8'h80);
    expect_reg("R2", 3'd4, 8'h80);
    expect_reg("R2", 3'd0, 8'h0F);
    expect_reg("R10", 3'd7, 8'h00);
    expect_irq("R10", 1'b0);
    pin[15] = 1'b1;
    tick(1); pin[15] = 1'b0;
    tick(4);
    expect_reg("R9", 3'd7, 8'h80);
    expect_reg("R9", 3'd3, 8'h00);
    expect_irq("R9", 1'b1);
    wr(3'd7, 8'h80);
    expect_reg("R9", 3'd7, 8'h00);
    expect_irq("R9", 1'b0);

    // R10: A3 falling -> rising with pin still, no spurious event
    config_port(1'b0, 8'h0F, 8'h0C, 8'h0D);
    tick(3); expect_reg("R10", 3'd3, 8'h00); expect_irq("R10", 1'b0);

    tick(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule